// File: doc/BRIEF.md
# Scanline Table Register Writer

This block runs up to eight independent channels that rewrite one fixed peripheral register per channel during each horizontal blanking gap. Each channel walks a table in system memory. Every table entry opens with a header byte. The low seven bits of the header are a line count, and the top bit marks whether fresh data follows for every line or a single value is written and then held. A header whose count is zero stops the channel until the next frame. The table can also hold 16-bit pointers instead of data. In that case the data bytes are read through the pointer from a per-channel bank.

Software fills in each channel's mode, target register, table start address and pointer bank through a small configuration port. It arms channels with a write-only enable mask. On each frame-start pulse the armed channels claim their slots away from the general block-transfer engine. They restart from their table start and read their first entry. On each blanking pulse, one sequencer serves the active channels in ascending index order. It shares a single memory read port and a single register write port among them.

Top module: `scanline_table_writer`

## Requirements
- R1: After reset no channel is claimed or active. `abus_rd` and `bbus_we` are low, and `gdma_grant` equals `gdma_req`.
- R2: The enable mask (bit n arms channel n) is sampled only on `frame_start`. Later writes take effect at the next frame start. For the whole frame, `gdma_grant` is held low for every channel claimed at frame start and follows `gdma_req` for the rest.
- R3: Configuration uses `cfg_sel`: 0 is the mode byte (bit 6 set selects pointer mode), 1 is the target register, 2/3/4 are the table start address bytes from low to high, and 5 is the pointer bank. On `frame_start`, every claimed channel reloads its table address from its start address and reads its first header (and pointer). No register write occurs before the first blanking pulse.
- R4: A header with bits 6:0 equal to zero ends the table (0x00 and 0x80 alike). The channel then makes no further reads or writes until the next frame start.
- R5: With header bit 7 clear and count C, the following unit is written on the first blanking pulse after the header is loaded. Nothing is written on the next C-1 pulses, and the next entry takes effect on the pulse after that.
- R6: With header bit 7 set and count C, C units follow the header and one is written on each of C consecutive blanking pulses. The next entry then takes effect.
- R7: In pointer mode, each header is followed by a 16-bit pointer stored low byte first. Units are read from address {bank, pointer}, and the pointer advances by one per unit.
- R8: In direct mode, units are read from consecutive table addresses that follow the header.
- R9: Each unit is written to `bbus_addr` equal to the channel's target register, with `bbus_wdata` equal to the byte read.
- R10: Within one blanking pulse, channels are served in ascending index order, so a lower channel's write precedes a higher channel's.
- R11: Reads are one-cycle `abus_rd` pulses with at most one read outstanding. A read is complete when `abus_rvalid` returns, which may be any later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| hblank | input | 1 | One-cycle pulse at each horizontal blanking gap |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 3 | Channel addressed by the configuration write |
| cfg_sel | input | 3 | Field selector for the configuration write |
| cfg_wdata | input | 8 | Configuration write data |
| en_we | input | 1 | Enable mask write strobe |
| en_wdata | input | 8 | Enable mask, one bit per channel |
| gdma_req | input | 8 | Block-transfer engine channel requests |
| gdma_grant | output | 8 | Channels the block-transfer engine may use |
| abus_rd | output | 1 | Memory read pulse |
| abus_addr | output | 24 | Memory read address |
| abus_rvalid | input | 1 | Memory read data valid |
| abus_rdata | input | 8 | Memory read data |
| bbus_we | output | 1 | Register write strobe |
| bbus_addr | output | 8 | Register write address |
| bbus_wdata | output | 8 | Register write data |

## Verification
On every cycle, the assertions check the read handshake: single-cycle pulses and one read outstanding. They check that claimed channels never reach the block-transfer engine and that a register write only ever comes from a channel that is active and claimed. They also check that a stopping header drops the channel while any other header raises it. What is written, to which register, and on which scanline can only be shown by the bench's scenarios. These scenarios cover the hold, repeat and pointer cases, their interleaving across channels, and a restart in the middle of a table. The bench also checks that a mask written in the middle of a frame takes effect only at the next frame start.

// File: rtl/stw_pkg.sv
package stw_pkg;

  localparam int SEL_MODE    = 0;
  localparam int SEL_TARGET  = 1;
  localparam int SEL_START_L = 2;
  localparam int SEL_START_M = 3;
  localparam int SEL_START_H = 4;
  localparam int SEL_BANK    = 5;
  localparam int MODE_PTR_BIT = 6;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PICK,
    ST_HDR_REQ,
    ST_HDR_WAIT,
    ST_PLO_REQ,
    ST_PLO_WAIT,
    ST_PHI_REQ,
    ST_PHI_WAIT,
    ST_DAT_REQ,
    ST_DAT_WAIT,
    ST_WRITE,
    ST_STEP
  } seq_state_e;

  function automatic logic [6:0] hdr_lines(input logic [7:0] h);
    return h[6:0];
  endfunction

  function automatic logic hdr_repeat(input logic [7:0] h);
    return h[7];
  endfunction

  function automatic logic hdr_stops(input logic [7:0] h);
    return (h[6:0] == 7'd0);
  endfunction

  function automatic logic [23:0] unit_addr(input logic ptr_mode,
                                            input logic [7:0] bank,
                                            input logic [15:0] ptr,
                                            input logic [23:0] tbl);
    return ptr_mode ? {bank, ptr} : tbl;
  endfunction

  function automatic logic last_line(input logic [6:0] left);
    return (left == 7'd1);
  endfunction

endpackage

// File: rtl/stw_pick.sv
module stw_pick #(
  parameter int N   = 8,
  parameter int CHW = $clog2(N)
) (
  input  logic [N-1:0]   mask,
  output logic           any,
  output logic [CHW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) begin
        any = 1'b1;
        idx = CHW'(i);
      end
    end
  end
endmodule

// File: rtl/stw_cfg.sv
module stw_cfg
  import stw_pkg::*;
#(
  parameter int N   = 8,
  parameter int CHW = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CHW-1:0]       cfg_ch,
  input  logic [2:0]           cfg_sel,
  input  logic [7:0]           cfg_wdata,
  input  logic                 en_we,
  input  logic [N-1:0]         en_wdata,
  input  logic                 frame_start,
  input  logic [N-1:0]         gdma_req,
  output logic [N-1:0]         ptr_mode,
  output logic [N-1:0][7:0]    target,
  output logic [N-1:0][23:0]   start,
  output logic [N-1:0][7:0]    bank,
  output logic [N-1:0]         claim,
  output logic [N-1:0]         gdma_grant
);
  logic [N-1:0] arm_q;

  for (genvar c = 0; c < N; c++) begin : g_chan
    logic hit;
    assign hit = cfg_we && (cfg_ch == CHW'(c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_mode[c] <= 1'b0;
        target[c]   <= '0;
        start[c]    <= '0;
        bank[c]     <= '0;
      end else if (hit) begin
        case (int'(cfg_sel))
          SEL_MODE:    ptr_mode[c]      <= cfg_wdata[MODE_PTR_BIT];
          SEL_TARGET:  target[c]        <= cfg_wdata;
          SEL_START_L: start[c][7:0]    <= cfg_wdata;
          SEL_START_M: start[c][15:8]   <= cfg_wdata;
          SEL_START_H: start[c][23:16]  <= cfg_wdata;
          SEL_BANK:    bank[c]          <= cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= '0;
      claim <= '0;
    end else begin
      if (en_we) arm_q <= en_wdata;
      if (frame_start) claim <= arm_q;
    end
  end

  assign gdma_grant = gdma_req & ~claim;
endmodule

// File: rtl/stw_seq.sv
module stw_seq
  import stw_pkg::*;
#(
  parameter int N   = 8,
  parameter int CHW = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic                 hblank,
  input  logic [N-1:0]         claim,
  input  logic [N-1:0]         ptr_mode,
  input  logic [N-1:0][7:0]    target,
  input  logic [N-1:0][23:0]   start,
  input  logic [N-1:0][7:0]    bank,
  output logic                 abus_rd,
  output logic [23:0]          abus_addr,
  input  logic                 abus_rvalid,
  input  logic [7:0]           abus_rdata,
  output logic                 bbus_we,
  output logic [7:0]           bbus_addr,
  output logic [7:0]           bbus_wdata,
  output logic [CHW-1:0]       cur_ch,
  output logic [N-1:0]         active,
  output logic                 ev_hdr,
  output logic                 ev_halt
);
  seq_state_e     state_q;
  logic [CHW-1:0] ch_q;
  logic [N-1:0]   todo_q;
  logic           init_q;
  logic           fs_pend_q;
  logic           hb_pend_q;
  logic [7:0]     dat_q;

  logic [N-1:0]   act_q;
  logic [N-1:0]   rep_q;
  logic [N-1:0]   xfer_q;
  logic [23:0]    tbl_q [N];
  logic [15:0]    ptr_q [N];
  logic [6:0]     left_q [N];

  logic           pick_any;
  logic [CHW-1:0] pick_idx;
  logic           cur_ptr;

  stw_pick #(.N(N), .CHW(CHW)) u_pick (
    .mask (todo_q),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  assign cur_ptr = ptr_mode[ch_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ch_q      <= '0;
      todo_q    <= '0;
      init_q    <= 1'b0;
      fs_pend_q <= 1'b0;
      hb_pend_q <= 1'b0;
      dat_q     <= '0;
      act_q     <= '0;
      rep_q     <= '0;
      xfer_q    <= '0;
      for (int i = 0; i < N; i++) begin
        tbl_q[i]  <= '0;
        ptr_q[i]  <= '0;
        left_q[i] <= '0;
      end
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (fs_pend_q) begin
            fs_pend_q <= 1'b0;
            init_q    <= 1'b1;
            todo_q    <= claim;
            act_q     <= '0;
            state_q   <= ST_PICK;
          end else if (hb_pend_q) begin
            hb_pend_q <= 1'b0;
            init_q    <= 1'b0;
            todo_q    <= act_q;
            state_q   <= ST_PICK;
          end
        end
        ST_PICK: begin
          if (!pick_any) begin
            state_q <= ST_IDLE;
          end else begin
            ch_q             <= pick_idx;
            todo_q[pick_idx] <= 1'b0;
            if (init_q) begin
              tbl_q[pick_idx] <= start[pick_idx];
              state_q         <= ST_HDR_REQ;
            end else if (xfer_q[pick_idx]) begin
              state_q <= ST_DAT_REQ;
            end else begin
              state_q <= ST_STEP;
            end
          end
        end
        ST_HDR_REQ: state_q <= ST_HDR_WAIT;
        ST_HDR_WAIT: begin
          if (abus_rvalid) begin
            tbl_q[ch_q] <= tbl_q[ch_q] + 24'd1;
            if (hdr_stops(abus_rdata)) begin
              act_q[ch_q] <= 1'b0;
              state_q     <= ST_PICK;
            end else begin
              act_q[ch_q]  <= 1'b1;
              left_q[ch_q] <= hdr_lines(abus_rdata);
              rep_q[ch_q]  <= hdr_repeat(abus_rdata);
              xfer_q[ch_q] <= 1'b1;
              state_q      <= cur_ptr ? ST_PLO_REQ : ST_PICK;
            end
          end
        end
        ST_PLO_REQ: state_q <= ST_PLO_WAIT;
        ST_PLO_WAIT: begin
          if (abus_rvalid) begin
            ptr_q[ch_q][7:0] <= abus_rdata;
            tbl_q[ch_q]      <= tbl_q[ch_q] + 24'd1;
            state_q          <= ST_PHI_REQ;
          end
        end
        ST_PHI_REQ: state_q <= ST_PHI_WAIT;
        ST_PHI_WAIT: begin
          if (abus_rvalid) begin
            ptr_q[ch_q][15:8] <= abus_rdata;
            tbl_q[ch_q]       <= tbl_q[ch_q] + 24'd1;
            state_q           <= ST_PICK;
          end
        end
        ST_DAT_REQ: state_q <= ST_DAT_WAIT;
        ST_DAT_WAIT: begin
          if (abus_rvalid) begin
            dat_q <= abus_rdata;
            if (cur_ptr) ptr_q[ch_q] <= ptr_q[ch_q] + 16'd1;
            else         tbl_q[ch_q] <= tbl_q[ch_q] + 24'd1;
            state_q <= ST_WRITE;
          end
        end
        ST_WRITE: state_q <= ST_STEP;
        ST_STEP: begin
          xfer_q[ch_q] <= rep_q[ch_q];
          if (last_line(left_q[ch_q])) begin
            left_q[ch_q] <= '0;
            state_q      <= ST_HDR_REQ;
          end else begin
            left_q[ch_q] <= left_q[ch_q] - 7'd1;
            state_q      <= ST_PICK;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      if (frame_start) fs_pend_q <= 1'b1;
      if (hblank)      hb_pend_q <= 1'b1;
    end
  end

  always_comb begin
    abus_rd = (state_q == ST_HDR_REQ) || (state_q == ST_PLO_REQ) ||
              (state_q == ST_PHI_REQ) || (state_q == ST_DAT_REQ);
    if (state_q == ST_DAT_REQ)
      abus_addr = unit_addr(cur_ptr, bank[ch_q], ptr_q[ch_q], tbl_q[ch_q]);
    else
      abus_addr = tbl_q[ch_q];
  end

  assign bbus_we    = (state_q == ST_WRITE);
  assign bbus_addr  = target[ch_q];
  assign bbus_wdata = dat_q;
  assign cur_ch     = ch_q;
  assign active     = act_q;
  assign ev_hdr     = (state_q == ST_HDR_WAIT) && abus_rvalid && !hdr_stops(abus_rdata);
  assign ev_halt    = (state_q == ST_HDR_WAIT) && abus_rvalid &&  hdr_stops(abus_rdata);
endmodule

// File: rtl/scanline_table_writer.sv
module scanline_table_writer #(
  parameter int N   = 8,
  parameter int CHW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_start,
  input  logic           hblank,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [2:0]     cfg_sel,
  input  logic [7:0]     cfg_wdata,
  input  logic           en_we,
  input  logic [N-1:0]   en_wdata,
  input  logic [N-1:0]   gdma_req,
  output logic [N-1:0]   gdma_grant,
  output logic           abus_rd,
  output logic [23:0]    abus_addr,
  input  logic           abus_rvalid,
  input  logic [7:0]     abus_rdata,
  output logic           bbus_we,
  output logic [7:0]     bbus_addr,
  output logic [7:0]     bbus_wdata
);
  logic [N-1:0]        ptr_mode;
  logic [N-1:0][7:0]   target;
  logic [N-1:0][23:0]  start;
  logic [N-1:0][7:0]   bank;
  logic [N-1:0]        claim;
  logic [CHW-1:0]      mon_ch;
  logic [N-1:0]        mon_act;
  logic                mon_hdr;
  logic                mon_halt;

  stw_cfg #(.N(N), .CHW(CHW)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_ch     (cfg_ch),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .en_we      (en_we),
    .en_wdata   (en_wdata),
    .frame_start(frame_start),
    .gdma_req   (gdma_req),
    .ptr_mode   (ptr_mode),
    .target     (target),
    .start      (start),
    .bank       (bank),
    .claim      (claim),
    .gdma_grant (gdma_grant)
  );

  stw_seq #(.N(N), .CHW(CHW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .hblank     (hblank),
    .claim      (claim),
    .ptr_mode   (ptr_mode),
    .target     (target),
    .start      (start),
    .bank       (bank),
    .abus_rd    (abus_rd),
    .abus_addr  (abus_addr),
    .abus_rvalid(abus_rvalid),
    .abus_rdata (abus_rdata),
    .bbus_we    (bbus_we),
    .bbus_addr  (bbus_addr),
    .bbus_wdata (bbus_wdata),
    .cur_ch     (mon_ch),
    .active     (mon_act),
    .ev_hdr     (mon_hdr),
    .ev_halt    (mon_halt)
  );
endmodule

// File: rtl/stw_checker.sv
module stw_checker #(
  parameter int N   = 8,
  parameter int CHW = $clog2(N)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           frame_start,
  input logic           en_we,
  input logic [N-1:0]   en_wdata,
  input logic [N-1:0]   gdma_req,
  input logic [N-1:0]   gdma_grant,
  input logic           abus_rd,
  input logic           abus_rvalid,
  input logic           bbus_we,
  input logic [CHW-1:0] mon_ch,
  input logic [N-1:0]   mon_act,
  input logic           mon_hdr,
  input logic           mon_halt
);
  logic [N-1:0] arm_sh;
  logic [N-1:0] claim_sh;
  logic [1:0]   outst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_sh   <= '0;
      claim_sh <= '0;
      outst    <= '0;
    end else begin
      if (en_we) arm_sh <= en_wdata;
      if (frame_start) claim_sh <= arm_sh;
      outst <= outst + {1'b0, abus_rd} - {1'b0, abus_rvalid};
    end
  end

  assert_rd_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    abus_rd |=> !abus_rd);

  assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
    abus_rd |-> (outst == 2'd0));

  assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gdma_grant & ~gdma_req) == '0);

  assert_grant_yields_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gdma_grant & claim_sh) == '0);

  assert_write_claimed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bbus_we |-> claim_sh[mon_ch]);

  assert_write_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bbus_we |-> mon_act[mon_ch]);

  assert_write_spaced_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bbus_we |=> !bbus_we);

  assert_halt_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mon_halt |=> !mon_act[$past(mon_ch)]);

  assert_hdr_raises_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mon_hdr |=> mon_act[$past(mon_ch)]);
endmodule

bind scanline_table_writer stw_checker #(.N(N), .CHW(CHW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_start(frame_start),
  .en_we      (en_we),
  .en_wdata   (en_wdata),
  .gdma_req   (gdma_req),
  .gdma_grant (gdma_grant),
  .abus_rd    (abus_rd),
  .abus_rvalid(abus_rvalid),
  .bbus_we    (bbus_we),
  .mon_ch     (mon_ch),
  .mon_act    (mon_act),
  .mon_hdr    (mon_hdr),
  .mon_halt   (mon_halt)
);

// File: tb/sim_scanline_table_writer.sv
`timescale 1ns/1ps
module sim_scanline_table_writer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0;
  logic       hblank = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_ch = '0;
  logic [2:0] cfg_sel = '0;
  logic [7:0] cfg_wdata = '0;
  logic       en_we = 1'b0;
  logic [7:0] en_wdata = '0;
  logic [7:0] gdma_req = '0;
  logic [7:0] gdma_grant;
  logic       abus_rd;
  logic [23:0] abus_addr;
  logic       abus_rvalid = 1'b0;
  logic [7:0] abus_rdata = '0;
  logic       bbus_we;
  logic [7:0] bbus_addr;
  logic [7:0] bbus_wdata;

  always #2.5 clk = ~clk;

  scanline_table_writer u0 (.*);

  byte unsigned mem [int];

  always_ff @(posedge clk) begin
    abus_rvalid <= abus_rd;
    abus_rdata  <= mem.exists(int'(abus_addr)) ? mem[int'(abus_addr)] : 8'h00;
  end

  typedef struct { int line; logic [7:0] a; logic [7:0] d; } exp_t;
  exp_t exp_q[$];
  int   checks = 0;
  int   failures = 0;
  int   cur_line = 0;
  int   rd_count = 0;
  bit   done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic expect_wr(input int line, input logic [7:0] a, input logic [7:0] d);
    exp_t e;
    e.line = line; e.a = a; e.d = d;
    exp_q.push_back(e);
  endtask

  // Scoreboard monitor: every register write must match the oldest expected item (R5 R6 R9 R10)
  always @(negedge clk) begin
    if (abus_rd) rd_count++;
    if (rst_n && bbus_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected write", {8'h0, 8'(cur_line), bbus_addr, bbus_wdata}, 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.line == cur_line && e.a == bbus_addr && e.d == bbus_wdata, "R9 write",
            {8'h0, 8'(cur_line), bbus_addr, bbus_wdata}, {8'h0, 8'(e.line), e.a, e.d});
      end
    end
  end

  task automatic cfg(input int ch, input int sel, input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_sel = 3'(sel); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_start(input int ch, input logic [23:0] a);
    cfg(ch, 2, a[7:0]);
    cfg(ch, 3, a[15:8]);
    cfg(ch, 4, a[23:16]);
  endtask

  task automatic set_en(input logic [7:0] m);
    @(negedge clk);
    en_we = 1'b1; en_wdata = m;
    @(negedge clk);
    en_we = 1'b0;
  endtask

  task automatic frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic line(input int n);
    cur_line = n;
    @(negedge clk);
    hblank = 1'b1;
    @(negedge clk);
    hblank = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic drained(input string req);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int rd_before;
    gdma_req = 8'hA5;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(bbus_we == 0, "R1 bbus_we", bbus_we, 0);
    chk(abus_rd == 0, "R1 abus_rd", abus_rd, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(gdma_grant == 8'hA5, "R1 grant", gdma_grant, 8'hA5);
    chk(abus_rd == 0, "R1 idle read", abus_rd, 0);

    // Frame A: direct table, hold entry then repeat entry (R5 R6 R8)
    mem[24'h0BE00F] = 8'h60;
    mem[24'h0BE010] = 8'h60;
    mem[24'h0BE011] = 8'h90;
    for (int i = 0; i < 16; i++) mem[24'h0BE012 + i] = 8'hA0 + 8'(i);
    mem[24'h0BE022] = 8'h00;
    cfg(3, 0, 8'h00);
    cfg(3, 1, 8'h26);
    cfg_start(3, 24'h0BE00F);
    set_en(8'h08);
    gdma_req = 8'hFF;
    @(negedge clk);
    chk(gdma_grant == 8'hFF, "R2 not yet claimed", gdma_grant, 8'hFF);
    frame();
    chk(gdma_grant == 8'hF7, "R2 claim", gdma_grant, 8'hF7);
    expect_wr(0, 8'h26, 8'h60);
    for (int i = 0; i < 16; i++) expect_wr(8'h60 + i, 8'h26, 8'hA0 + 8'(i));
    for (int n = 0; n < 8'h73; n++) line(n);
    drained("R6 all units written");

    // Frame B: pointer mode on ch0 with ch5 direct, ordering (R7 R10 R4)
    mem[24'h001000] = 8'h83;
    mem[24'h001001] = 8'h00; mem[24'h001002] = 8'h20;
    mem[24'h001003] = 8'h02;
    mem[24'h001004] = 8'h00; mem[24'h001005] = 8'h30;
    mem[24'h001006] = 8'h80;
    mem[24'h7E2000] = 8'h11; mem[24'h7E2001] = 8'h22; mem[24'h7E2002] = 8'h33;
    mem[24'h7E3000] = 8'h44;
    mem[24'h002000] = 8'hEE;
    mem[24'h020000] = 8'h01; mem[24'h020001] = 8'h55;
    mem[24'h020002] = 8'h01; mem[24'h020003] = 8'h66;
    mem[24'h020004] = 8'h00;
    cfg(0, 0, 8'h40);
    cfg(0, 1, 8'h21);
    cfg(0, 5, 8'h7E);
    cfg_start(0, 24'h001000);
    cfg(5, 0, 8'h00);
    cfg(5, 1, 8'h05);
    cfg_start(5, 24'h020000);
    set_en(8'h21);
    rd_before = rd_count;
    frame();
    chk(rd_count - rd_before == 4, "R3 frame start reads", rd_count - rd_before, 4);
    chk(exp_q.size() == 0, "R3 no write before blanking", exp_q.size(), 0);
    chk(gdma_grant == 8'hDE, "R2 claim B", gdma_grant, 8'hDE);
    set_en(8'h01);
    chk(gdma_grant == 8'hDE, "R2 mid-frame mask ignored", gdma_grant, 8'hDE);
    expect_wr(0, 8'h21, 8'h11);
    expect_wr(0, 8'h05, 8'h55);
    expect_wr(1, 8'h21, 8'h22);
    expect_wr(1, 8'h05, 8'h66);
    expect_wr(2, 8'h21, 8'h33);
    expect_wr(3, 8'h21, 8'h44);
    for (int n = 0; n < 5; n++) line(n);
    drained("R7 pointer units");
    rd_before = rd_count;
    for (int n = 5; n < 9; n++) line(n);
    chk(rd_count == rd_before, "R4 no reads after stop", rd_count - rd_before, 0);

    // Frame C: new mask takes effect, ch0 restarts from table start (R2 R3)
    frame();
    chk(gdma_grant == 8'hFE, "R2 new mask", gdma_grant, 8'hFE);
    expect_wr(0, 8'h21, 8'h11);
    expect_wr(1, 8'h21, 8'h22);
    line(0);
    line(1);
    drained("R3 restart C");

    // Frame D: restart in the middle of a table (R3)
    frame();
    expect_wr(0, 8'h21, 8'h11);
    expect_wr(1, 8'h21, 8'h22);
    expect_wr(2, 8'h21, 8'h33);
    line(0);
    line(1);
    line(2);
    drained("R3 mid-table restart");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule